// File: doc/BRIEF.md
# Configurable-Format Asynchronous Serial Transmitter

This block turns characters from a parallel stream input into asynchronous serial frames on a single output line. The frame format comes from a seven-bit control field and may change at run time. The field sets the character length (5 to 8 bits), one or two stop bits (one and a half with 5-bit characters), an optional parity bit with odd, even, forced-one or forced-zero modes, and a break override that pulls the line low.

Characters enter through a valid/ready handshake. `in_ready` is high only while the transmitter is idle. A character is taken on a rising clock edge where both `in_valid` and `in_ready` are high. `in_ready` then stays low for the whole frame, so the sender must hold its character and `in_valid` until `in_ready` returns. A valid presented while the transmitter is busy has no effect. Bit timing comes from `tick_i`, a one-cycle enable that pulses sixteen times per bit period. Baud division happens outside this block.

The format is captured when a character is accepted, so a control change during a frame shapes only the next frame. Break is the exception: it acts on the line at once, and the frame timing keeps running underneath it.

Top module: `uftx_top`

## Requirements
- R1: Control bits [1:0] set the character length as 5 plus their value (00 gives 5 bits, 11 gives 8). Data bits are sent least significant bit first.
- R2: Control bit 2 at 0 gives one stop bit (16 ticks). At 1 it gives two stop bits (32 ticks), except with bits [1:0] = 00, where it gives one and a half (24 ticks). Stop bits are driven high.
- R3: Control bit 3 at 1 inserts a parity bit of 16 ticks after the data bits. At 0 there is no parity bit.
- R4: Control bits [5:4] pick the parity value. 00 is odd (data plus parity hold an odd count of ones), 01 is even, 10 forces 1, and 11 forces 0.
- R5: While control bit 6 is 1, `txd_o` is 0, both when idle and in mid-frame. Frame timing is not disturbed.
- R6: After reset `txd_o` is 1 and `in_ready` is 1. The captured format is all zeros.
- R7: A frame starts with a 0 start bit. Every start, data and parity bit lasts 16 ticks. The line is 1 when idle.
- R8: The format is captured when a character is accepted. Changing control bits 0 to 5 during a frame does not change that frame.
- R9: A character is accepted only while `in_ready` is 1. `in_ready` falls in the cycle after acceptance and rises in the cycle after the tick that ends the final stop bit. A valid held while busy is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ctrl_i | input | 7 | Frame control: [1:0] length, [2] stop, [3] parity enable, [5:4] parity mode, [6] break |
| tick_i | input | 1 | Baud enable, 16 pulses per bit |
| in_valid | input | 1 | Character valid |
| in_data | input | 8 | Character, LSB sent first |
| in_ready | output | 1 | High when idle and able to accept |
| txd_o | output | 1 | Serial output, idle high |

## Verification
Two functions can act in the same cycle. One is the break override, which acts on the live control field. The other is frame sequencing, which runs on the captured format and can be crossing a bit boundary or finishing a stop bit in that cycle. The bench opens break windows at random tick offsets inside frames while it also rewrites the other control bits in mid-frame. It then checks every tick sample against the frame computed from the captured format, with break substituted only inside the window. The total tick count to `in_ready` must also match the unbroken frame length, which shows that break leaves the timing alone.

// File: rtl/uftx_pkg.sv
package uftx_pkg;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_START = 3'd1,
    ST_DATA  = 3'd2,
    ST_PAR   = 3'd3,
    ST_STOP  = 3'd4
  } tx_state_e;

  typedef enum logic [1:0] {
    PAR_ODD   = 2'b00,
    PAR_EVEN  = 2'b01,
    PAR_MARK  = 2'b10,
    PAR_SPACE = 2'b11
  } par_mode_e;

  typedef struct packed {
    logic [1:0] len_code;
    logic       long_stop;
    logic       par_en;
    par_mode_e  par_mode;
  } frame_fmt_t;

endpackage

// File: rtl/uftx_fmt_decode.sv
module uftx_fmt_decode
  import uftx_pkg::*;
(
  input  logic [6:0]  ctrl,
  output frame_fmt_t  fmt,
  output logic        brk
);
  always_comb begin
    fmt.len_code  = ctrl[1:0];
    fmt.long_stop = ctrl[2];
    fmt.par_en    = ctrl[3];
    fmt.par_mode  = par_mode_e'(ctrl[5:4]);
    brk           = ctrl[6];
  end
endmodule

// File: rtl/uftx_parity.sv
module uftx_parity
  import uftx_pkg::*;
#(
  parameter int DATA_W   = 8,
  parameter int MIN_BITS = 5
) (
  input  logic [DATA_W-1:0] data,
  input  logic [1:0]        len_code,
  input  par_mode_e         mode,
  output logic              par_bit
);
  logic [DATA_W-1:0] keep;
  logic              ones_odd;

  for (genvar i = 0; i < DATA_W; i++) begin : g_keep
    if (i < MIN_BITS) begin : g_fixed
      assign keep[i] = 1'b1;
    end else begin : g_var
      assign keep[i] = (32'(len_code) + 32'(MIN_BITS)) > 32'(i);
    end
  end

  assign ones_odd = ^(data & keep);

  always_comb begin
    unique case (mode)
      PAR_ODD:   par_bit = ~ones_odd;
      PAR_EVEN:  par_bit = ones_odd;
      PAR_MARK:  par_bit = 1'b1;
      default:   par_bit = 1'b0;
    endcase
  end
endmodule

// File: rtl/uftx_seq.sv
module uftx_seq
  import uftx_pkg::*;
#(
  parameter int DATA_W   = 8,
  parameter int TPB      = 16,
  parameter int MIN_BITS = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  frame_fmt_t        fmt_live,
  input  logic              tick_i,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] in_data,
  output logic              in_ready,
  output logic              line_bit
);
  localparam int CNT_W = $clog2(2 * TPB);
  localparam int IDX_W = $clog2(DATA_W);
  localparam logic [CNT_W-1:0] BIT_LAST  = CNT_W'(TPB - 1);
  localparam logic [CNT_W-1:0] ONEH_LAST = CNT_W'(TPB + TPB / 2 - 1);
  localparam logic [CNT_W-1:0] TWO_LAST  = CNT_W'(2 * TPB - 1);

  tx_state_e         state_q;
  logic [CNT_W-1:0]  tcnt_q;
  logic [IDX_W-1:0]  bidx_q;
  logic [DATA_W-1:0] data_q;
  frame_fmt_t        fmt_q;
  logic [IDX_W-1:0]  last_idx;
  logic [CNT_W-1:0]  stop_last;
  logic [CNT_W-1:0]  span_last;
  logic              par_bit;
  logic              span_end;

  uftx_parity #(.DATA_W(DATA_W), .MIN_BITS(MIN_BITS)) par_i (
    .data     (data_q),
    .len_code (fmt_q.len_code),
    .mode     (fmt_q.par_mode),
    .par_bit  (par_bit)
  );

  assign last_idx  = IDX_W'(MIN_BITS - 1) + IDX_W'(fmt_q.len_code);
  assign stop_last = !fmt_q.long_stop      ? BIT_LAST :
                     (fmt_q.len_code == '0) ? ONEH_LAST : TWO_LAST;
  assign span_last = (state_q == ST_STOP) ? stop_last : BIT_LAST;
  assign span_end  = tick_i && (tcnt_q == span_last);
  assign in_ready  = (state_q == ST_IDLE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      tcnt_q  <= '0;
      bidx_q  <= '0;
      data_q  <= '0;
      fmt_q   <= '0;
    end else if (state_q == ST_IDLE) begin
      if (in_valid) begin
        data_q  <= in_data;
        fmt_q   <= fmt_live;
        tcnt_q  <= '0;
        bidx_q  <= '0;
        state_q <= ST_START;
      end
    end else if (tick_i) begin
      if (!span_end) begin
        tcnt_q <= tcnt_q + 1'b1;
      end else begin
        tcnt_q <= '0;
        unique case (state_q)
          ST_START: state_q <= ST_DATA;
          ST_DATA: begin
            if (bidx_q == last_idx) state_q <= fmt_q.par_en ? ST_PAR : ST_STOP;
            else                    bidx_q  <= bidx_q + 1'b1;
          end
          ST_PAR:  state_q <= ST_STOP;
          default: state_q <= ST_IDLE;
        endcase
      end
    end
  end

  always_comb begin
    unique case (state_q)
      ST_START: line_bit = 1'b0;
      ST_DATA:  line_bit = data_q[bidx_q];
      ST_PAR:   line_bit = par_bit;
      default:  line_bit = 1'b1;
    endcase
  end

  // R9
  ready_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> !in_ready);

  // R9
  ready_after_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(in_ready) |-> ($past(state_q) == ST_STOP && $past(tick_i)));

  // R8
  fmt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q != ST_IDLE && $past(state_q) != ST_IDLE) |-> $stable(fmt_q));

endmodule

// File: rtl/uftx_line_drive.sv
module uftx_line_drive (
  input  logic brk,
  input  logic line_bit,
  output logic txd
);
  assign txd = line_bit & ~brk;
endmodule

// File: rtl/uftx_top.sv
module uftx_top
  import uftx_pkg::*;
#(
  parameter int DATA_W   = 8,
  parameter int TPB      = 16,
  parameter int MIN_BITS = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [6:0]        ctrl_i,
  input  logic              tick_i,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] in_data,
  output logic              in_ready,
  output logic              txd_o
);
  frame_fmt_t fmt_live;
  logic       brk;
  logic       line_bit;

  uftx_fmt_decode dec_i (
    .ctrl (ctrl_i),
    .fmt  (fmt_live),
    .brk  (brk)
  );

  uftx_seq #(.DATA_W(DATA_W), .TPB(TPB), .MIN_BITS(MIN_BITS)) seq_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .fmt_live (fmt_live),
    .tick_i   (tick_i),
    .in_valid (in_valid),
    .in_data  (in_data),
    .in_ready (in_ready),
    .line_bit (line_bit)
  );

  uftx_line_drive drv_i (
    .brk      (brk),
    .line_bit (line_bit),
    .txd      (txd_o)
  );

  // R7
  idle_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_ready && !ctrl_i[6]) |-> txd_o);

  // R7
  start_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> !txd_o);

  // R5
  brk_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_i[6] |-> !txd_o);

endmodule

// File: tb/uftx_top_tb_top.sv
module uftx_top_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [6:0] ctrl_i = '0;
  logic       in_valid = 1'b0;
  logic [7:0] in_data = '0;
  logic       in_ready;
  logic       txd_o;
  logic       tick_i;
  logic [1:0] tdiv = '0;
  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  always @(posedge clk) tdiv <= (tdiv == 2'd2) ? 2'd0 : tdiv + 2'd1;
  assign tick_i = (tdiv == 2'd0);

  uftx_top dut_i (
    .clk(clk), .rst_n(rst_n), .ctrl_i(ctrl_i), .tick_i(tick_i),
    .in_valid(in_valid), .in_data(in_data), .in_ready(in_ready), .txd_o(txd_o)
  );

  function automatic int nbits(input logic [6:0] c);
    return 5 + int'(c[1:0]);
  endfunction

  function automatic int stop_ticks(input logic [6:0] c);
    if (!c[2]) return 16;
    return (c[1:0] == 2'b00) ? 24 : 32;
  endfunction

  function automatic int frame_ticks(input logic [6:0] c);
    return 16 * (1 + nbits(c) + int'(c[3])) + stop_ticks(c);
  endfunction

  function automatic logic par_of(input logic [6:0] c, input logic [7:0] d);
    logic p = 1'b0;
    for (int i = 0; i < nbits(c); i++) p ^= d[i];
    case (c[5:4])
      2'b00: return ~p;
      2'b01: return p;
      2'b10: return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  function automatic logic exp_bit(input logic [6:0] c, input logic [7:0] d, input int k);
    int b = k / 16;
    if (b == 0) return 1'b0;
    if (b <= nbits(c)) return d[b-1];
    if (c[3] && b == nbits(c) + 1) return par_of(c, d);
    return 1'b1;
  endfunction

  function automatic string region(input logic [6:0] c, input int k);
    int b = k / 16;
    if (b == 0) return "R7 start";
    if (b <= nbits(c)) return "R1 data";
    if (c[3] && b == nbits(c) + 1) return "R4 parity";
    return "R2 stop";
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic send(input logic [6:0] c, input logic [7:0] d, input logic [6:0] c2,
                      input int bs, input int be, input bit hold, input string tag);
    int k = 0;
    bit brk = 0;
    @(negedge clk);
    ctrl_i = c; in_data = d; in_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    in_valid = hold; in_data = ~d; ctrl_i = c2;
    while (!in_ready) begin
      if (tick_i) begin
        logic e;
        e = brk ? 1'b0 : exp_bit(c, d, k);
        checks++;
        if (txd_o !== e) begin
          errors++;
          $display("FAIL %s %s tick %0d ctrl=%h data=%h actual=%0d expected=%0d",
                   tag, brk ? "R5 break" : region(c, k), k, c, d, txd_o, e);
        end
        k++;
      end
      if (k > 400) break;
      brk = (k >= bs) && (k < be);
      ctrl_i = c2 | (brk ? 7'h40 : 7'h00);
      @(negedge clk);
    end
    in_valid = 1'b0;
    ctrl_i = c2;
    check(k == frame_ticks(c), {tag, " R2 R3 R9 frame ticks"}, k, frame_ticks(c));
    check(txd_o === 1'b1, {tag, " R7 idle high"}, txd_o, 1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R6 reset state
    check(in_ready === 1'b1, "R6 ready after reset", in_ready, 1);
    check(txd_o === 1'b1, "R6 line after reset", txd_o, 1);

    // R5 break while idle, ready unaffected
    ctrl_i = 7'h40;
    @(negedge clk);
    check(txd_o === 1'b0, "R5 idle break", txd_o, 0);
    check(in_ready === 1'b1, "R5 R9 ready during idle break", in_ready, 1);
    ctrl_i = 7'h00;
    @(negedge clk);
    check(txd_o === 1'b1, "R5 break released", txd_o, 1);

    // every format, directed corners on data
    for (int f = 0; f < 64; f++) begin
      logic [7:0] d;
      d = (f % 4 == 0) ? 8'h00 : (f % 4 == 1) ? 8'hFF : 8'($urandom);
      send(7'(f), d, 7'(f), 10000, 10000, 1'b0, "fmt");
    end

    // R8 random: mid-frame format change, break windows, held valid (R9)
    for (int n = 0; n < 30; n++) begin
      logic [6:0] c, c2;
      int bs, be;
      c  = 7'($urandom) & 7'h3F;
      c2 = 7'($urandom) & 7'h3F;
      if ($urandom % 3 == 0) begin
        bs = 1 + int'($urandom % 120);
        be = bs + 1 + int'($urandom % 40);
      end else begin
        bs = 10000; be = 10000;
      end
      send(c, 8'($urandom), c2, bs, be, 1'($urandom), "R8");
    end

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule